// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial input into data words. A pulse at sixteen times the baud rate paces it. An 8-bit control byte sets the frame format: five to eight data bits sent least significant bit first, an optional parity bit that can be checked as odd, even, always-one or always-zero, and a stop bit. Each received frame produces a zero-extended 8-bit word, a one-cycle valid strobe, and flags for parity error, framing error and line break.

The serial input passes through a synchronizer. A falling edge on an idle line is taken as a possible start bit and is checked again at mid-bit. Every later bit is sampled once at its centre. The control byte is captured when a start bit is confirmed, so changing it during a frame does not affect that frame. After a frame whose stop bit reads low, the receiver does not look for a new start bit until the line has gone high again.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, `data_valid`, `data_out`, `parity_err`, `frame_err` and `break_det` are all zero until the first frame completes.
- R2: `ctrl[1:0]` sets the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. `data_out` holds them right-aligned, and the bits above the count are zero.
- R3: A low level seen on an idle line is sampled again eight ticks later. If the line is high by then, the event is dropped and no frame is reported.
- R4: When `ctrl[3]` is 1, one parity bit follows the data. With `ctrl[5]`=0, `ctrl[4]`=0 expects odd parity and `ctrl[4]`=1 expects even parity over data plus parity bit. `parity_err` is set on a mismatch. When `ctrl[3]` is 0, no parity bit is sampled and `parity_err` stays 0.
- R5: When `ctrl[3]`=1 and `ctrl[5]`=1, the parity bit must be 1 if `ctrl[4]`=0 and must be 0 if `ctrl[4]`=1. Any other value sets `parity_err`.
- R6: `frame_err` is set when the first stop bit is sampled low.
- R7: `break_det` is set when every data bit, the parity bit (if enabled) and the stop bit are sampled low. A break always reports `frame_err` and a zero `data_out`.
- R8: After a frame with a low stop bit, no new start bit is accepted until the line has been seen high. A line held low produces exactly one report.
- R9: Only the first stop bit is checked, whatever the value of `ctrl[2]`. A start bit that follows straight after one stop bit is received.
- R10: `data_valid` is high for exactly one cycle, in the cycle after the tick that samples the stop bit centre. `data_out` and the flags change only with that strobe and hold their values until the next one.
- R11: The format is taken from `ctrl` when the start bit is confirmed. Changes to `ctrl` later in the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | Enable pulse at sixteen times the baud rate |
| rx_in | input | 1 | Serial input, idles high |
| ctrl | input | 8 | Frame format control byte |
| data_out | output | 8 | Received word, zero-extended |
| data_valid | output | 1 | One-cycle strobe when a frame completes |
| parity_err | output | 1 | Parity mismatch in the last frame |
| frame_err | output | 1 | Stop bit sampled low in the last frame |
| break_det | output | 1 | All frame bits sampled low in the last frame |

## Verification
The strobe for a frame with k data, parity and stop bits is due 8+16k ticks after the tick that first sees the low start level. That tick comes two synchronizer cycles plus up to one tick period after the input edge, and the output register adds one more cycle. With four clocks per tick, the bench measures the delay from the edge it drives to the strobe and requires it to fall within 64k+28 to 64k+46 cycles. For false starts, held-low lines and back-to-back frames, the bench counts the strobes seen over a fixed number of bit periods. All outputs are sampled on the falling clock edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_MAX = 8;
  localparam int IDX_W    = $clog2(DATA_MAX);

  typedef enum logic [2:0] {
    S_HUNT,   // waiting for the line to go high
    S_IDLE,   // line high, watching for a low level
    S_START,  // counting to the start-bit centre
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_t;

  typedef struct packed {
    logic [1:0] len;       // data bits minus five
    logic       pen;       // parity bit present
    logic       even_sel;  // even parity, or forced-zero when forcing
    logic       force_par; // parity forced to a constant
  } rx_cfg_t;
endpackage

// File: rtl/uart_rx_rst_sync.sv
module uart_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_line_sync.sv
module uart_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], din};
  end

  assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity_ref.sv
module uart_rx_parity_ref
  import uart_rx_pkg::*;
(
  input  logic [DATA_MAX-1:0] data,
  input  logic                even_sel,
  input  logic                force_par,
  output logic                exp_bit
);
  // Unused upper data bits are zero, so reducing over the full width is safe.
  always_comb begin
    if (force_par)     exp_bit = ~even_sel;
    else if (even_sel) exp_bit = ^data;
    else               exp_bit = ~^data;
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx,
  input  rx_cfg_t             ctrl_cfg,
  input  logic                exp_par,
  output rx_cfg_t             cfg_q,
  output logic [DATA_MAX-1:0] shift_q,
  output logic [DATA_MAX-1:0] data_out,
  output logic                data_valid,
  output logic                parity_err,
  output logic                frame_err,
  output logic                break_det
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OS_RATE / 2 - 1);

  rx_state_t           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [DATA_MAX-1:0] shift_d;
  logic                par_q, par_d;
  logic                zero_q, zero_d;
  rx_cfg_t             cfg_d;
  logic [DATA_MAX-1:0] out_q, out_d;
  logic                vld_q, vld_d;
  logic                pe_q, pe_d, fe_q, fe_d, bk_q, bk_d;
  logic                at_centre;
  logic [IDX_W-1:0]    last_idx;

  assign at_centre = tick && (cnt_q == CNT_LAST);
  assign last_idx  = IDX_W'(cfg_q.len) + IDX_W'(4);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    par_d   = par_q;
    zero_d  = zero_q;
    cfg_d   = cfg_q;
    out_d   = out_q;
    pe_d    = pe_q;
    fe_d    = fe_q;
    bk_d    = bk_q;
    vld_d   = 1'b0;
    if (tick && state_q != S_HUNT && state_q != S_IDLE) cnt_d = cnt_q + 1'b1;
    unique case (state_q)
      S_HUNT:  if (tick && rx) state_d = S_IDLE;
      S_IDLE:  if (tick && !rx) begin
                 state_d = S_START;
                 cnt_d   = '0;
               end
      S_START: if (tick && cnt_q == CNT_MID) begin
                 if (!rx) begin
                   state_d = S_DATA;
                   cnt_d   = '0;
                   idx_d   = '0;
                   shift_d = '0;
                   zero_d  = 1'b1;
                   cfg_d   = ctrl_cfg;
                 end else begin
                   state_d = S_IDLE;
                 end
               end
      S_DATA:  if (at_centre) begin
                 shift_d[idx_q] = rx;
                 zero_d         = zero_q & ~rx;
                 cnt_d          = '0;
                 if (idx_q == last_idx) state_d = cfg_q.pen ? S_PAR : S_STOP;
                 else                   idx_d   = idx_q + 1'b1;
               end
      S_PAR:   if (at_centre) begin
                 par_d   = rx;
                 zero_d  = zero_q & ~rx;
                 cnt_d   = '0;
                 state_d = S_STOP;
               end
      S_STOP:  if (at_centre) begin
                 vld_d   = 1'b1;
                 out_d   = shift_q;
                 pe_d    = cfg_q.pen & (par_q ^ exp_par);
                 fe_d    = ~rx;
                 bk_d    = zero_q & ~rx;
                 cnt_d   = '0;
                 state_d = rx ? S_IDLE : S_HUNT;
               end
      default: state_d = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      cfg_q   <= '0;
      out_q   <= '0;
      vld_q   <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      bk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      par_q   <= par_d;
      zero_q  <= zero_d;
      cfg_q   <= cfg_d;
      out_q   <= out_d;
      vld_q   <= vld_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      bk_q    <= bk_d;
    end
  end

  assign data_out   = out_q;
  assign data_valid = vld_q;
  assign parity_err = pe_q;
  assign frame_err  = fe_q;
  assign break_det  = bk_q;
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic [7:0] ctrl,
  output logic [7:0] data_out,
  output logic       data_valid,
  output logic       parity_err,
  output logic       frame_err,
  output logic       break_det
);
  logic                rst_sync_n;
  logic                rx_s;
  logic                exp_par;
  rx_cfg_t             ctrl_cfg;
  rx_cfg_t             cfg_q;
  logic [DATA_MAX-1:0] shift_q;
  logic                unused_ctrl_bits;

  // Stop-bit count and the two upper control bits do not change reception.
  assign unused_ctrl_bits = ^{ctrl[7:6], ctrl[2]};

  assign ctrl_cfg = '{len: ctrl[1:0], pen: ctrl[3], even_sel: ctrl[4], force_par: ctrl[5]};

  uart_rx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  uart_rx_line_sync #(.STAGES(SYNC_STAGES)) u_line_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(rx_in), .dout(rx_s)
  );

  uart_rx_parity_ref u_parity (
    .data(shift_q), .even_sel(cfg_q.even_sel), .force_par(cfg_q.force_par), .exp_bit(exp_par)
  );

  uart_rx_engine #(.OS_RATE(OS_RATE)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick16), .rx(rx_s),
    .ctrl_cfg(ctrl_cfg), .exp_par(exp_par), .cfg_q(cfg_q), .shift_q(shift_q),
    .data_out(data_out), .data_valid(data_valid), .parity_err(parity_err),
    .frame_err(frame_err), .break_det(break_det)
  );
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_valid,
  input logic [7:0] data_out,
  input logic       parity_err,
  input logic       frame_err,
  input logic       break_det,
  input logic       cfg_pen,
  input logic [1:0] cfg_len
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid); // R10

  AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable({data_out, parity_err, frame_err, break_det})); // R10

  AST_BREAK_IS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && break_det) |-> (frame_err && data_out == 8'd0)); // R7

  AST_NO_PARITY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !cfg_pen) |-> !parity_err); // R4

  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ((data_out >> (4'd5 + {2'b00, cfg_len})) == 8'd0)); // R2
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .data_out(data_out),
  .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det),
  .cfg_pen(cfg_q.pen), .cfg_len(cfg_q.len)
);

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;
  localparam int TICK_DIV = 4;
  localparam int OS       = 16;
  localparam int BIT      = TICK_DIV * OS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [7:0] ctrl = 8'h03;
  logic [7:0] data_out;
  logic       data_valid, parity_err, frame_err, break_det;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, tdiv = 0;
  int vcount = 0, run = 0, maxrun = 0, cap_cycle = 0;
  logic [7:0] cap_data = '0;
  logic cap_pe = 0, cap_fe = 0, cap_bk = 0;
  bit done = 0;

  uart_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in), .ctrl(ctrl),
    .data_out(data_out), .data_valid(data_valid), .parity_err(parity_err),
    .frame_err(frame_err), .break_det(break_det)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tdiv == TICK_DIV - 1) begin tdiv <= 0; tick16 <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick16 <= 1'b0; end
  end

  always @(negedge clk) begin
    if (data_valid) begin
      vcount++; run++;
      cap_data = data_out; cap_pe = parity_err; cap_fe = frame_err; cap_bk = break_det;
      cap_cycle = cyc;
    end else run = 0;
    if (run > maxrun) maxrun = run;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit pen, input bit pv,
                      input bit sv, output int t0);
    @(negedge clk); rx_in = 1'b0; t0 = cyc;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < n; i++) begin rx_in = d[i]; repeat (BIT) @(negedge clk); end
    if (pen) begin rx_in = pv; repeat (BIT) @(negedge clk); end
    rx_in = sv; repeat (BIT) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic expect_frame(input string req, input int v0, input int t0, input int k,
                              input logic [7:0] ed, input bit epe, input bit efe, input bit ebk);
    int lat;
    lat = cap_cycle - t0;
    chk(vcount == v0 + 1, req, "strobe count", vcount, v0 + 1);
    chk(cap_data == ed, req, "data", cap_data, ed);
    chk(cap_pe == epe, req, "parity_err", cap_pe, epe);
    chk(cap_fe == efe, req, "frame_err", cap_fe, efe);
    chk(cap_bk == ebk, req, "break_det", cap_bk, ebk);
    chk(lat >= BIT*k + 28 && lat <= BIT*k + 46, "R10", "strobe latency", lat, BIT*k + 37);
  endtask

  function automatic bit odd_bit(input logic [7:0] d); return ~^d; endfunction

  task automatic t_reset();
    chk(data_valid == 0, "R1", "valid after reset", data_valid, 0);
    chk(data_out == 0, "R1", "data after reset", data_out, 0);
    chk({parity_err, frame_err, break_det} == 0, "R1", "flags after reset",
        {parity_err, frame_err, break_det}, 0);
  endtask

  task automatic t_eight_bits();
    int v0, t0;
    ctrl = 8'h03; v0 = vcount;
    send(8'hA5, 8, 0, 0, 1, t0); repeat (BIT) @(negedge clk);
    expect_frame("R2", v0, t0, 9, 8'hA5, 0, 0, 0);
    chk(maxrun == 1, "R10", "strobe width", maxrun, 1);
    repeat (3 * BIT) @(negedge clk);
    chk(data_out == 8'hA5, "R10", "data held", data_out, 8'hA5);
  endtask

  task automatic t_lengths();
    int v0, t0;
    for (int n = 5; n <= 7; n++) begin
      logic [7:0] exp_d;
      exp_d = 8'hD6 & 8'((1 << n) - 1);
      ctrl = 8'(n - 5); v0 = vcount;
      send(8'hD6, n, 0, 0, 1, t0); repeat (BIT) @(negedge clk);
      expect_frame("R2", v0, t0, n + 1, exp_d, 0, 0, 0);
    end
  endtask

  task automatic t_parity();
    int v0, t0;
    logic [7:0] d = 8'h37;
    for (int ev = 0; ev < 2; ev++) begin
      for (int bad = 0; bad < 2; bad++) begin
        bit pbit;
        pbit = (ev == 1) ? ~odd_bit(d) : odd_bit(d);
        if (bad == 1) pbit = ~pbit;
        ctrl = (ev == 1) ? 8'h1B : 8'h0B; v0 = vcount;
        send(d, 8, 1, pbit, 1, t0); repeat (BIT) @(negedge clk);
        expect_frame("R4", v0, t0, 10, d, bad[0], 0, 0);
      end
    end
    ctrl = 8'h03; v0 = vcount;
    send(8'h01, 8, 0, 0, 1, t0); repeat (BIT) @(negedge clk);
    expect_frame("R4", v0, t0, 9, 8'h01, 0, 0, 0);
  endtask

  task automatic t_forced();
    int v0, t0;
    for (int f0 = 0; f0 < 2; f0++) begin
      for (int pv = 0; pv < 2; pv++) begin
        bit want;
        want = (f0 == 0);
        ctrl = (f0 == 1) ? 8'h3B : 8'h2B; v0 = vcount;
        send(8'h5A, 8, 1, pv[0], 1, t0); repeat (BIT) @(negedge clk);
        expect_frame("R5", v0, t0, 10, 8'h5A, pv[0] != want, 0, 0);
      end
    end
  endtask

  task automatic t_framing();
    int v0, t0;
    ctrl = 8'h03; v0 = vcount;
    send(8'h55, 8, 0, 0, 0, t0); rx_in = 1'b0;
    expect_frame("R6", v0, t0, 9, 8'h55, 0, 1, 0);
    repeat (6 * BIT) @(negedge clk);
    chk(vcount == v0 + 1, "R8", "no frame while held low", vcount, v0 + 1);
    rx_in = 1'b1; repeat (2 * BIT) @(negedge clk);
    v0 = vcount;
    send(8'h3C, 8, 0, 0, 1, t0); repeat (BIT) @(negedge clk);
    expect_frame("R8", v0, t0, 9, 8'h3C, 0, 0, 0);
  endtask

  task automatic t_break();
    int v0, t0;
    ctrl = 8'h0B; v0 = vcount;
    @(negedge clk); rx_in = 1'b0; t0 = cyc;
    repeat (14 * BIT) @(negedge clk);
    expect_frame("R7", v0, t0, 10, 8'h00, odd_bit(8'h00), 1, 1);
    rx_in = 1'b1; repeat (2 * BIT) @(negedge clk);
    chk(vcount == v0 + 1, "R8", "one report for held break", vcount, v0 + 1);
  endtask

  task automatic t_false_start();
    int v0, t0;
    ctrl = 8'h03; v0 = vcount;
    @(negedge clk); rx_in = 1'b0;
    repeat (12) @(negedge clk); rx_in = 1'b1;
    repeat (20 * BIT) @(negedge clk);
    chk(vcount == v0, "R3", "false start discarded", vcount, v0);
    send(8'h81, 8, 0, 0, 1, t0); repeat (BIT) @(negedge clk);
    expect_frame("R3", v0, t0, 9, 8'h81, 0, 0, 0);
  endtask

  task automatic t_one_stop();
    int v0, t0, t1;
    ctrl = 8'h07; v0 = vcount;
    send(8'hE7, 8, 0, 0, 1, t0);
    chk(vcount == v0 + 1 && cap_data == 8'hE7, "R9", "first of pair", cap_data, 8'hE7);
    send(8'h18, 8, 0, 0, 1, t1); repeat (BIT) @(negedge clk);
    expect_frame("R9", v0 + 1, t1, 9, 8'h18, 0, 0, 0);
  endtask

  task automatic t_ctrl_mid();
    int v0, t0;
    ctrl = 8'h03; v0 = vcount;
    fork
      send(8'hC3, 8, 0, 0, 1, t0);
      begin repeat (2 * BIT) @(negedge clk); ctrl = 8'h08; end
    join
    repeat (BIT) @(negedge clk);
    expect_frame("R11", v0, t0, 9, 8'hC3, 0, 0, 0);
    ctrl = 8'h03;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset();
    t_eight_bits();
    t_lengths();
    t_parity();
    t_forced();
    t_framing();
    t_break();
    t_false_start();
    t_one_stop();
    t_ctrl_mid();
    chk(maxrun == 1, "R10", "strobe width overall", maxrun, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule